// File: doc/BRIEF.md
# Five-State Snooping Line Coherence Controller

This block tracks the coherence state of every line of one cache that sits on a broadcast bus with peer caches. Each line is in one of five states: invalid, shared, exclusive, owned or modified. The processor side issues reads and writes. The block decides whether a request completes locally or needs a bus transaction: a read, a read-for-ownership, an invalidate or a writeback of a dirty victim. On the bus side it watches transactions from peers. It answers with a shared indication and a supply-data indication, and it downgrades or invalidates its own copy.

The block holds a small direct-mapped tag and state array so that it can be used and tested alone. Data arrays, bus arbitration and the peers lie outside it. A coherence unit is one line of `LINE_BYTES` bytes, 32 by default. Addresses are byte addresses, and every bus address is line-aligned. An exclusive line is written with no bus traffic. An owned line keeps dirty data while peers hold shared copies, and it answers peer reads in place of memory.

Protocol on the processor side: `cpu_req_i`, `cpu_we_i` and `cpu_addr_i` are held until `cpu_done_o` pulses for one cycle. On the bus side, the block raises `bus_req_o` with `bus_op_o` and `bus_addr_o` until it gets a one-cycle `bus_gnt_i`. The transaction completes at that edge, and `bus_shared_i` is sampled with the grant.

Top module: `coh_line_ctrl`

## Requirements
- R1: After reset every line is invalid, `cpu_done_o`, `bus_req_o`, `snp_shared_o` and `snp_supply_o` are low, and the first access to any line misses.
- R2: A read miss requests bus op 0 (read) at the line-aligned address (low `log2(LINE_BYTES)` bits zero). The line fills as exclusive when `bus_shared_i` is low at the grant, and as shared when it is high. `cpu_done_o` pulses in the cycle after the grant.
- R3: A read hit to any valid state, or a write hit to a modified line, raises `cpu_done_o` in the cycle after the request is accepted, with no bus request.
- R4: A write hit to an exclusive line completes like R3, with no bus request, and leaves the line modified.
- R5: A write hit to a shared or owned line requests bus op 2 (invalidate) for that line and leaves it modified after the grant.
- R6: A write miss requests bus op 1 (read-for-ownership) and fills the line as modified.
- R7: On a miss whose victim is modified or owned, the block first requests bus op 3 (writeback) at the victim's address, then the fill. A shared or exclusive victim is dropped with no writeback.
- R8: A snooped read (op 0) that hits a modified line asserts `snp_shared_o` and `snp_supply_o` in that cycle and moves the line to owned. A snooped read that hits an owned line supplies again and leaves it owned.
- R9: A snooped read that hits an exclusive or shared line asserts only `snp_shared_o`, and an exclusive line becomes shared.
- R10: A snooped read-for-ownership (op 1) that hits invalidates the line and asserts `snp_supply_o` if the line was modified or owned. A snooped invalidate (op 2) invalidates the line with no response.
- R11: A snoop that misses (invalid line or tag mismatch), or a snooped writeback (op 3), gives no response and leaves the line unchanged.
- R12: A snoop in a cycle with `bus_gnt_i` high is ignored: no response and no state change.
- R13: A processor request whose line index matches a snoop in the same cycle is not accepted that cycle. The snoop takes effect first, and the request is accepted in a later cycle against the updated state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cpu_req_i | input | 1 | Processor request, held until done |
| cpu_we_i | input | 1 | 1 = write, 0 = read |
| cpu_addr_i | input | ADDR_W | Processor byte address |
| cpu_done_o | output | 1 | One-cycle completion pulse |
| bus_req_o | output | 1 | Bus transaction request |
| bus_op_o | output | 2 | 0 read, 1 read-for-ownership, 2 invalidate, 3 writeback |
| bus_addr_o | output | ADDR_W | Line-aligned transaction address |
| bus_gnt_i | input | 1 | One-cycle grant; the transaction completes at this edge |
| bus_shared_i | input | 1 | A peer holds the line; sampled with the grant |
| snp_valid_i | input | 1 | A peer transaction is visible on the bus |
| snp_op_i | input | 2 | Snooped op, same encoding as bus_op_o |
| snp_addr_i | input | ADDR_W | Snooped address |
| snp_shared_o | output | 1 | This cache holds the snooped line (combinational) |
| snp_supply_o | output | 1 | This cache supplies the snooped line's data (combinational) |

## Verification
Snoop responses are combinational, so the bench reads them 1 ns after it drives the snoop, and the resulting state change is in place by the following edge. A hit is accepted at the first edge after the request, and `cpu_done_o` is sampled at the next falling edge, so a hit has to finish exactly one cycle after it is driven. On a miss, `bus_req_o` shows at that same falling edge. The bench grants at that falling edge. It then expects either `cpu_done_o` or the next operation, such as the fill after a writeback, at the falling edge after the grant. It counts operations and records their codes and addresses. The state of a line is then inferred at the ports: whether a later write needs the bus, and what a later snoop reports.

// File: rtl/coh_pkg.sv
package coh_pkg;
  typedef enum logic [2:0] {
    ST_I = 3'd0,
    ST_S = 3'd1,
    ST_E = 3'd2,
    ST_O = 3'd3,
    ST_M = 3'd4
  } line_st_e;

  typedef enum logic [1:0] {
    OP_RD  = 2'd0,
    OP_RDX = 2'd1,
    OP_INV = 2'd2,
    OP_WB  = 2'd3
  } bus_op_e;
endpackage

// File: rtl/coh_tag_store.sv
module coh_tag_store
  import coh_pkg::*;
#(
  parameter int SETS  = 8,
  parameter int TAG_W = 24,
  parameter int IDX_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] a_idx_i,
  output logic [TAG_W-1:0] a_tag_o,
  output line_st_e         a_st_o,
  input  logic [IDX_W-1:0] b_idx_i,
  output logic [TAG_W-1:0] b_tag_o,
  output line_st_e         b_st_o,
  input  logic             f_we_i,
  input  logic [IDX_W-1:0] f_idx_i,
  input  logic [TAG_W-1:0] f_tag_i,
  input  line_st_e         f_st_i,
  input  logic             s_we_i,
  input  logic [IDX_W-1:0] s_idx_i,
  input  line_st_e         s_st_i
);
  logic [TAG_W-1:0] tag_w [SETS];
  line_st_e         st_w  [SETS];

  for (genvar g = 0; g < SETS; g++) begin : g_set
    logic [TAG_W-1:0] tag_r;
    line_st_e         st_r;
    // snoop port wins; the request side never writes the snooped index in the same cycle
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        tag_r <= '0;
        st_r  <= ST_I;
      end else if (s_we_i && s_idx_i == IDX_W'(g)) begin
        st_r  <= s_st_i;
      end else if (f_we_i && f_idx_i == IDX_W'(g)) begin
        st_r  <= f_st_i;
        tag_r <= f_tag_i;
      end
    end
    assign tag_w[g] = tag_r;
    assign st_w[g]  = st_r;
  end

  assign a_tag_o = tag_w[a_idx_i];
  assign a_st_o  = st_w[a_idx_i];
  assign b_tag_o = tag_w[b_idx_i];
  assign b_st_o  = st_w[b_idx_i];
endmodule

// File: rtl/coh_snoop_unit.sv
module coh_snoop_unit
  import coh_pkg::*;
#(
  parameter int TAG_W = 24
) (
  input  logic             valid_i,
  input  logic             gnt_i,
  input  bus_op_e          op_i,
  input  logic [TAG_W-1:0] tag_i,
  input  logic [TAG_W-1:0] line_tag_i,
  input  line_st_e         line_st_i,
  output logic             shared_o,
  output logic             supply_o,
  output logic             we_o,
  output line_st_e         nxt_st_o
);
  logic hit;
  logic dirty;

  assign hit   = valid_i && !gnt_i && line_st_i != ST_I && tag_i == line_tag_i;
  assign dirty = line_st_i == ST_M || line_st_i == ST_O;

  always_comb begin
    shared_o = 1'b0;
    supply_o = 1'b0;
    we_o     = 1'b0;
    nxt_st_o = line_st_i;
    if (hit) begin
      unique case (op_i)
        OP_RD: begin
          shared_o = 1'b1;
          supply_o = dirty;
          if (line_st_i == ST_M) nxt_st_o = ST_O;
          else if (line_st_i == ST_E) nxt_st_o = ST_S;
          we_o = nxt_st_o != line_st_i;
        end
        OP_RDX: begin
          supply_o = dirty;
          nxt_st_o = ST_I;
          we_o     = 1'b1;
        end
        OP_INV: begin
          nxt_st_o = ST_I;
          we_o     = 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/coh_req_fsm.sv
module coh_req_fsm
  import coh_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 3,
  parameter int TAG_W  = 24,
  parameter int OFF_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  output logic              cpu_done_o,
  output logic [IDX_W-1:0]  lk_idx_o,
  input  logic [TAG_W-1:0]  lk_tag_i,
  input  line_st_e          lk_st_i,
  input  logic              snp_valid_i,
  input  logic [IDX_W-1:0]  snp_idx_i,
  input  logic              bus_gnt_i,
  input  logic              bus_shared_i,
  output logic              bus_req_o,
  output bus_op_e           bus_op_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic              f_we_o,
  output logic [IDX_W-1:0]  f_idx_o,
  output logic [TAG_W-1:0]  f_tag_o,
  output line_st_e          f_st_o
);
  typedef enum logic {F_IDLE, F_BUS} fsm_e;

  fsm_e st_q, st_d;
  logic done_q, done_d;

  logic [IDX_W-1:0] req_idx;
  logic [TAG_W-1:0] req_tag;
  logic             hit, victim_dirty, clash;
  logic             unused_off;

  assign req_idx    = cpu_addr_i[OFF_W +: IDX_W];
  assign req_tag    = cpu_addr_i[ADDR_W-1 -: TAG_W];
  assign unused_off = ^cpu_addr_i[OFF_W-1:0];

  assign hit          = lk_st_i != ST_I && lk_tag_i == req_tag;
  assign victim_dirty = lk_st_i == ST_M || lk_st_i == ST_O;
  assign clash        = snp_valid_i && snp_idx_i == req_idx;

  assign lk_idx_o = req_idx;
  assign f_idx_o  = req_idx;

  // op re-derived every cycle so a snoop that drops the line while waiting changes it
  always_comb begin
    if (!hit && victim_dirty) bus_op_o = OP_WB;
    else if (!hit)            bus_op_o = cpu_we_i ? OP_RDX : OP_RD;
    else                      bus_op_o = OP_INV;
  end

  assign bus_addr_o = (bus_op_o == OP_WB) ? {lk_tag_i, req_idx, {OFF_W{1'b0}}}
                                          : {req_tag,  req_idx, {OFF_W{1'b0}}};
  assign bus_req_o  = st_q == F_BUS;

  always_comb begin
    st_d    = st_q;
    done_d  = 1'b0;
    f_we_o  = 1'b0;
    f_tag_o = req_tag;
    f_st_o  = lk_st_i;
    unique case (st_q)
      F_IDLE: begin
        if (cpu_req_i && !done_q && !clash) begin
          if (hit && (!cpu_we_i || lk_st_i == ST_M)) begin
            done_d = 1'b1;
          end else if (hit && lk_st_i == ST_E) begin
            f_we_o = 1'b1;
            f_st_o = ST_M;
            done_d = 1'b1;
          end else begin
            st_d = F_BUS;
          end
        end
      end
      F_BUS: begin
        if (bus_gnt_i) begin
          f_we_o = 1'b1;
          unique case (bus_op_o)
            OP_WB: begin
              f_st_o  = ST_I;
              f_tag_o = lk_tag_i;
            end
            OP_RD:   f_st_o = bus_shared_i ? ST_S : ST_E;
            default: f_st_o = ST_M;
          endcase
          if (bus_op_o != OP_WB) begin
            done_d = 1'b1;
            st_d   = F_IDLE;
          end
        end
      end
      default: st_d = F_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= F_IDLE;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
    end
  end

  assign cpu_done_o = done_q;
endmodule

// File: rtl/coh_line_ctrl.sv
module coh_line_ctrl
  import coh_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int SETS       = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  output logic              cpu_done_o,
  output logic              bus_req_o,
  output logic [1:0]        bus_op_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  input  logic              bus_gnt_i,
  input  logic              bus_shared_i,
  input  logic              snp_valid_i,
  input  logic [1:0]        snp_op_i,
  input  logic [ADDR_W-1:0] snp_addr_i,
  output logic              snp_shared_o,
  output logic              snp_supply_o
);
  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

  logic [IDX_W-1:0] lk_idx, snp_idx, f_idx;
  logic [TAG_W-1:0] lk_tag, snp_tag, ln_tag, f_tag;
  line_st_e         lk_st, ln_st, f_st, s_st;
  logic             f_we, s_we;
  bus_op_e          fsm_op;
  logic             unused_snp_off;

  assign snp_idx        = snp_addr_i[OFF_W +: IDX_W];
  assign snp_tag        = snp_addr_i[ADDR_W-1 -: TAG_W];
  assign unused_snp_off = ^snp_addr_i[OFF_W-1:0];

  coh_tag_store #(.SETS(SETS), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_store (
    .clk_i, .rst_ni,
    .a_idx_i(lk_idx),  .a_tag_o(lk_tag), .a_st_o(lk_st),
    .b_idx_i(snp_idx), .b_tag_o(ln_tag), .b_st_o(ln_st),
    .f_we_i(f_we), .f_idx_i(f_idx), .f_tag_i(f_tag), .f_st_i(f_st),
    .s_we_i(s_we), .s_idx_i(snp_idx), .s_st_i(s_st)
  );

  coh_snoop_unit #(.TAG_W(TAG_W)) u_snoop (
    .valid_i(snp_valid_i), .gnt_i(bus_gnt_i), .op_i(bus_op_e'(snp_op_i)),
    .tag_i(snp_tag), .line_tag_i(ln_tag), .line_st_i(ln_st),
    .shared_o(snp_shared_o), .supply_o(snp_supply_o),
    .we_o(s_we), .nxt_st_o(s_st)
  );

  coh_req_fsm #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .TAG_W(TAG_W), .OFF_W(OFF_W)) u_fsm (
    .clk_i, .rst_ni,
    .cpu_req_i, .cpu_we_i, .cpu_addr_i, .cpu_done_o,
    .lk_idx_o(lk_idx), .lk_tag_i(lk_tag), .lk_st_i(lk_st),
    .snp_valid_i, .snp_idx_i(snp_idx),
    .bus_gnt_i, .bus_shared_i, .bus_req_o,
    .bus_op_o(fsm_op), .bus_addr_o,
    .f_we_o(f_we), .f_idx_o(f_idx), .f_tag_o(f_tag), .f_st_o(f_st)
  );

  assign bus_op_o = fsm_op;
endmodule

// File: rtl/coh_checker.sv
module coh_checker #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cpu_req_i,
  input logic              cpu_done_o,
  input logic              bus_req_o,
  input logic [1:0]        bus_op_o,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic              bus_gnt_i,
  input logic              snp_valid_i,
  input logic [1:0]        snp_op_i,
  input logic              snp_shared_o,
  input logic              snp_supply_o
);
  a_r3_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_done_o |=> !cpu_done_o);

  a_r3_done_no_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_done_o |-> !bus_req_o);

  a_r2_line_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> bus_addr_o[OFF_W-1:0] == '0);

  a_r7_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_gnt_i && cpu_req_i |=> bus_req_o);

  a_r5_op_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_gnt_i && !snp_valid_i && cpu_req_i |=> $stable(bus_op_o));

  a_r11_quiet_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !snp_valid_i |-> !snp_shared_o && !snp_supply_o);

  a_r11_wb_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_valid_i && snp_op_i == 2'd3 |-> !snp_shared_o && !snp_supply_o);

  a_r12_gnt_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_gnt_i |-> !snp_shared_o && !snp_supply_o);
endmodule

bind coh_line_ctrl coh_checker #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cpu_req_i(cpu_req_i), .cpu_done_o(cpu_done_o),
  .bus_req_o(bus_req_o), .bus_op_o(bus_op_o), .bus_addr_o(bus_addr_o),
  .bus_gnt_i(bus_gnt_i), .snp_valid_i(snp_valid_i), .snp_op_i(snp_op_i),
  .snp_shared_o(snp_shared_o), .snp_supply_o(snp_supply_o)
);

// File: tb/sim_coh_line_ctrl.sv
`timescale 1ns/1ps
module sim_coh_line_ctrl;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [31:0] cpu_addr = '0;
  logic        cpu_done;
  logic        bus_req;
  logic [1:0]  bus_op;
  logic [31:0] bus_addr;
  logic        bus_gnt = 1'b0, bus_shared = 1'b0;
  logic        snp_valid = 1'b0;
  logic [1:0]  snp_op = '0;
  logic [31:0] snp_addr = '0;
  logic        snp_shared, snp_supply;

  int n_vec = 0, n_bad = 0;

  int          acc_nops, acc_cyc;
  logic        acc_done;
  logic [1:0]  acc_op [4];
  logic [31:0] acc_addr [4];
  logic        inj_en = 1'b0;
  logic [1:0]  inj_op = '0;
  logic [31:0] inj_addr = '0;
  logic        inj_sh, inj_sup;
  logic        s_sh, s_sup;

  always #(CLK_P/2) clk = ~clk;

  coh_line_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .cpu_req_i(cpu_req), .cpu_we_i(cpu_we), .cpu_addr_i(cpu_addr), .cpu_done_o(cpu_done),
    .bus_req_o(bus_req), .bus_op_o(bus_op), .bus_addr_o(bus_addr),
    .bus_gnt_i(bus_gnt), .bus_shared_i(bus_shared),
    .snp_valid_i(snp_valid), .snp_op_i(snp_op), .snp_addr_i(snp_addr),
    .snp_shared_o(snp_shared), .snp_supply_o(snp_supply)
  );

  function automatic logic [31:0] mk(input int tag, input int idx);
    return {tag[23:0], idx[2:0], 5'b0};
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // drives one request, grants every bus op, records ops until done
  task automatic access(input logic we, input logic [31:0] a, input logic sh);
    acc_nops = 0;
    acc_cyc  = 0;
    acc_done = 1'b0;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      acc_cyc++;
      bus_gnt = 1'b0; bus_shared = 1'b0; snp_valid = 1'b0;
      if (cpu_done) begin
        acc_done = 1'b1;
        break;
      end
      if (bus_req) begin
        if (acc_nops < 4) begin
          acc_op[acc_nops]   = bus_op;
          acc_addr[acc_nops] = bus_addr;
        end
        acc_nops++;
        bus_gnt = 1'b1; bus_shared = sh;
        if (inj_en) begin
          snp_valid = 1'b1; snp_op = inj_op; snp_addr = inj_addr;
          #1;
          inj_sh = snp_shared; inj_sup = snp_supply;
          inj_en = 1'b0;
        end
      end
    end
    cpu_req = 1'b0;
    if (!acc_done) begin
      n_vec++; n_bad++;
      $display("FAIL access: actual no done expected done");
    end
  endtask

  task automatic snoop(input logic [1:0] op, input logic [31:0] a);
    @(negedge clk);
    snp_valid = 1'b1; snp_op = op; snp_addr = a;
    #1;
    s_sh = snp_shared; s_sup = snp_supply;
    @(negedge clk);
    snp_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "done in reset", cpu_done, 0);
    chk("R1", "bus_req in reset", bus_req, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "outputs after reset", {snp_shared, snp_supply, bus_req, cpu_done}, 0);
    access(1'b0, mk(1, 0) + 4, 1'b0);
    chk("R1", "first read misses", acc_nops, 1);
    chk("R2", "read op", acc_op[0], 0);
    chk("R2", "aligned addr", acc_addr[0], mk(1, 0));
    chk("R2", "done after grant", acc_cyc, 2);
  endtask

  task automatic t_exclusive_owned();
    access(1'b0, mk(1, 0), 1'b0);
    chk("R3", "read hit cycles", acc_cyc, 1);
    chk("R3", "read hit no bus", acc_nops, 0);
    access(1'b1, mk(1, 0), 1'b0);
    chk("R4", "E write silent", acc_nops, 0);
    chk("R4", "E write cycles", acc_cyc, 1);
    snoop(2'd0, mk(1, 0));
    chk("R8", "M snoop rd resp", {s_sh, s_sup}, 2'b11);
    snoop(2'd0, mk(1, 0));
    chk("R8", "O snoop rd resp", {s_sh, s_sup}, 2'b11);
    access(1'b1, mk(1, 0), 1'b0);
    chk("R5", "O write ops", acc_nops, 1);
    chk("R5", "O write inv", acc_op[0], 2);
    access(1'b1, mk(1, 0), 1'b0);
    chk("R5", "modified after inv", acc_nops, 0);
    snoop(2'd0, mk(1, 0));
    chk("R8", "M again to O", {s_sh, s_sup}, 2'b11);
  endtask

  task automatic t_shared_fill();
    access(1'b0, mk(2, 1), 1'b1);
    chk("R2", "shared fill op", acc_op[0], 0);
    snoop(2'd0, mk(2, 1));
    chk("R9", "S snoop rd resp", {s_sh, s_sup}, 2'b10);
    access(1'b1, mk(2, 1), 1'b0);
    chk("R5", "S write inv", acc_op[0], 2);
    chk("R5", "S write addr", acc_addr[0], mk(2, 1));
  endtask

  task automatic t_e_to_s();
    access(1'b0, mk(3, 2), 1'b0);
    snoop(2'd0, mk(3, 2));
    chk("R9", "E snoop rd resp", {s_sh, s_sup}, 2'b10);
    access(1'b1, mk(3, 2), 1'b0);
    chk("R9", "E became S", acc_op[0], 2);
    chk("R9", "one op", acc_nops, 1);
  endtask

  task automatic t_write_miss();
    access(1'b1, mk(4, 3), 1'b0);
    chk("R6", "write miss op", acc_op[0], 1);
    chk("R6", "write miss ops", acc_nops, 1);
    access(1'b1, mk(4, 3), 1'b0);
    chk("R6", "filled modified", acc_nops, 0);
  endtask

  task automatic t_evict();
    access(1'b0, mk(5, 0), 1'b0);
    chk("R7", "O evict ops", acc_nops, 2);
    chk("R7", "O evict wb", acc_op[0], 3);
    chk("R7", "wb victim addr", acc_addr[0], mk(1, 0));
    chk("R7", "then read", acc_op[1], 0);
    chk("R7", "fill addr", acc_addr[1], mk(5, 0));
    access(1'b1, mk(10, 3), 1'b0);
    chk("R7", "M evict wb", acc_op[0], 3);
    chk("R7", "M victim addr", acc_addr[0], mk(4, 3));
    chk("R7", "then rdx", acc_op[1], 1);
    access(1'b0, mk(6, 4), 1'b0);
    access(1'b0, mk(7, 4), 1'b0);
    chk("R7", "E evict silent", acc_nops, 1);
    access(1'b0, mk(8, 5), 1'b1);
    access(1'b0, mk(9, 5), 1'b1);
    chk("R7", "S evict silent", acc_nops, 1);
    chk("R7", "S evict op", acc_op[0], 0);
  endtask

  task automatic t_snoop_inval();
    snoop(2'd1, mk(10, 3));
    chk("R10", "rdx on M resp", {s_sh, s_sup}, 2'b01);
    access(1'b0, mk(10, 3), 1'b0);
    chk("R10", "invalid after rdx", acc_nops, 1);
    chk("R10", "no wb after rdx", acc_op[0], 0);
    snoop(2'd2, mk(9, 5));
    chk("R10", "inv resp", {s_sh, s_sup}, 2'b00);
    access(1'b1, mk(9, 5), 1'b0);
    chk("R10", "invalid after inv", acc_op[0], 1);
  endtask

  task automatic t_snoop_miss();
    snoop(2'd0, mk(11, 6));
    chk("R11", "empty line resp", {s_sh, s_sup}, 2'b00);
    snoop(2'd0, mk(99, 2));
    chk("R11", "tag mismatch resp", {s_sh, s_sup}, 2'b00);
    snoop(2'd3, mk(3, 2));
    chk("R11", "wb snoop resp", {s_sh, s_sup}, 2'b00);
    access(1'b1, mk(3, 2), 1'b0);
    chk("R11", "line still M", acc_nops, 0);
  endtask

  task automatic t_snoop_on_grant();
    inj_en = 1'b1; inj_op = 2'd1; inj_addr = mk(3, 2);
    access(1'b0, mk(12, 7), 1'b0);
    chk("R12", "no resp on grant", {inj_sh, inj_sup}, 2'b00);
    access(1'b1, mk(3, 2), 1'b0);
    chk("R12", "line kept M", acc_nops, 0);
  endtask

  task automatic t_clash();
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = mk(3, 2);
    snp_valid = 1'b1; snp_op = 2'd0; snp_addr = mk(3, 2);
    #1;
    chk("R13", "snoop served", {snp_shared, snp_supply}, 2'b11);
    @(negedge clk);
    snp_valid = 1'b0;
    chk("R13", "stalled", cpu_done, 0);
    @(negedge clk);
    chk("R13", "accepted later", cpu_done, 1);
    cpu_req = 1'b0;
    access(1'b1, mk(3, 2), 1'b0);
    chk("R13", "snoop applied first", acc_op[0], 2);
  endtask

  initial begin
    #(CLK_P * 100000);
    n_vec++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    t_exclusive_owned();
    t_shared_fill();
    t_e_to_s();
    t_write_miss();
    t_evict();
    t_snoop_inval();
    t_snoop_miss();
    t_snoop_on_grant();
    t_clash();
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule